// File: doc/BRIEF.md
# Receive FIFO with Hysteresis-Based Automatic RTS

This block buffers received UART characters with their error tags and drives the active-low request-to-send pin in hardware. Each entry holds an 8-bit character and 3 error tag bits. The oldest entry is always shown on the read outputs. A host read strobe removes that entry.

The fill level is compared against a programmed trigger level. A data-ready interrupt is raised at the trigger level. Under automatic control the RTS pin stays low at the trigger. It goes high only at an upper limit, which is the trigger plus a hysteresis value. It goes low again only when reads bring the level down to a lower limit, which is the trigger minus the hysteresis value. Characters that arrive while RTS is high are still stored until the buffer is physically full. When automatic control is disabled, the pin simply mirrors the software request bit.

Top module: `rx_flow_fifo`

## Requirements
- R1: Entries leave in write order. `rd_data`/`rd_err` show the oldest stored character and its 3 tag bits exactly as written. A read strobe while entries are stored removes that entry.
- R2: The buffer holds 128 entries. A write while 128 entries are stored is dropped, and it sets `overrun`. `overrun` then stays set until reset.
- R3: A read and a write in the same cycle with 1 to 127 entries stored leave the level unchanged. A read while empty is ignored and does not disturb later data.
- R4: `rx_trig_irq` is high exactly when the level is nonzero and at least `trig_lvl`.
- R5: With `auto_en` set and `rts_req` low, `rts_n` stays high whatever the level. Automatic control starts once `rts_req` is high, with `rts_n` low.
- R6: While automatic control holds `rts_n` low, reaching the trigger level leaves `rts_n` low. `rts_n` goes high one cycle after the level reaches the upper limit `trig_lvl + hyst`.
- R7: After going high under automatic control, `rts_n` returns low one cycle after the level falls to the lower limit `trig_lvl - hyst`.
- R8: Writes are still accepted while `rts_n` is high, up to the full 128 entries.
- R9: When automatic control drives `rts_n` high and `rts_ie` is 1, `rts_off_irq` is set. A `rts_off_clr` pulse clears it. With `rts_ie` at 0 the flag is not set.
- R10: With `auto_en` low, `rts_n` equals the inverse of `rts_req`.
- R11: After reset the buffer is empty. `rts_n` is high (with `rts_req` low), and `rx_trig_irq`, `rts_off_irq` and `overrun` are 0.
- R12: The upper limit saturates at 128. The lower limit floors at 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| wr_en | input | 1 | Received-character write strobe |
| wr_data | input | 8 | Received character |
| wr_err | input | 3 | Error tags of the received character |
| rd_en | input | 1 | Host read strobe, removes the head entry |
| auto_en | input | 1 | Automatic RTS control enable |
| rts_req | input | 1 | Software RTS request |
| rts_ie | input | 1 | RTS-off interrupt enable |
| rts_off_clr | input | 1 | Host read of the RTS-off flag, clears it |
| trig_lvl | input | 8 | Receive trigger level |
| hyst | input | 8 | Hysteresis distance |
| rts_n | output | 1 | Active-low request-to-send pin |
| rx_trig_irq | output | 1 | Data-ready trigger interrupt |
| rts_off_irq | output | 1 | Sticky RTS-off interrupt flag |
| overrun | output | 1 | Sticky overrun flag |
| rd_data | output | 8 | Head character |
| rd_err | output | 3 | Head error tags |

## Verification
The flow-control path is driven through several fill-and-drain profiles:
- A trigger of 16 with hysteresis 8. This separates the interrupt threshold from the RTS-off threshold, and the RTS-off threshold from the RTS-on threshold.
- A trigger of 120 with hysteresis 20, and a trigger of 4 with hysteresis 10. These expose a missing saturation at 128 or a missing floor at 0.
- Fills with the request low, and fills with the interrupt enable low. These show that the pin and the flag are gated by those bits.
- A fill past 128. This distinguishes a dropped write from a wrapped pointer.

Mixed same-cycle reads and writes, and a read while empty, run through the ordering scoreboard. They show that order and tags survive those cases.

// File: rtl/rxf_pkg.sv
package rxf_pkg;
  typedef enum logic [1:0] {
    RTS_IDLE = 2'd0,
    RTS_ON   = 2'd1,
    RTS_OFF  = 2'd2
  } rts_state_e;
endpackage

// File: rtl/rxf_store.sv
module rxf_store #(
  parameter int W     = 11,
  parameter int DEPTH = 128,
  parameter int CNT_W = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             push,
  input  logic             pop,
  input  logic [W-1:0]     din,
  output logic [W-1:0]     dout,
  output logic [CNT_W-1:0] count
);
  localparam int PTR_W = (DEPTH > 1) ? $clog2(DEPTH) : 1;
  localparam logic [PTR_W-1:0] LAST = PTR_W'(DEPTH - 1);

  logic [W-1:0]     mem [DEPTH];
  logic [PTR_W-1:0] wp_q, wp_d, rp_q, rp_d;
  logic [CNT_W-1:0] cnt_q, cnt_d;

  always_comb begin
    wp_d  = wp_q;
    rp_d  = rp_q;
    cnt_d = cnt_q;
    if (push) wp_d = (wp_q == LAST) ? '0 : wp_q + 1'b1;
    if (pop)  rp_d = (rp_q == LAST) ? '0 : rp_q + 1'b1;
    case ({push, pop})
      2'b10:   cnt_d = cnt_q + 1'b1;
      2'b01:   cnt_d = cnt_q - 1'b1;
      default: cnt_d = cnt_q;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wp_q  <= '0;
      rp_q  <= '0;
      cnt_q <= '0;
    end else begin
      wp_q  <= wp_d;
      rp_q  <= rp_d;
      cnt_q <= cnt_d;
    end
  end

  always_ff @(posedge clk) begin
    if (push) mem[wp_q] <= din;
  end

  assign dout  = mem[rp_q];
  assign count = cnt_q;
endmodule

// File: rtl/rxf_limits.sv
module rxf_limits #(
  parameter int DEPTH = 128,
  parameter int CNT_W = 8
) (
  input  logic [CNT_W-1:0] trig,
  input  logic [CNT_W-1:0] hyst,
  output logic [CNT_W-1:0] hi,
  output logic [CNT_W-1:0] lo
);
  localparam logic [CNT_W:0] CAP = (CNT_W + 1)'(DEPTH);

  logic [CNT_W:0] sum;

  always_comb begin
    sum = {1'b0, trig} + {1'b0, hyst};
    hi  = (sum >= CAP) ? CAP[CNT_W-1:0] : sum[CNT_W-1:0];
    lo  = (trig > hyst) ? (trig - hyst) : '0;
  end
endmodule

// File: rtl/rxf_rts_ctl.sv
module rxf_rts_ctl
  import rxf_pkg::*;
#(
  parameter int CNT_W = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             auto_en,
  input  logic             rts_req,
  input  logic             rts_ie,
  input  logic             off_clr,
  input  logic [CNT_W-1:0] count,
  input  logic [CNT_W-1:0] hi,
  input  logic [CNT_W-1:0] lo,
  output logic             rts_n,
  output logic             off_flag
);
  rts_state_e st_q, st_d;
  logic       flag_q, flag_d;

  always_comb begin
    st_d   = st_q;
    flag_d = flag_q;
    if (!auto_en || !rts_req) begin
      st_d = RTS_IDLE;
    end else begin
      case (st_q)
        RTS_IDLE: st_d = RTS_ON;
        RTS_ON:   if (count >= hi) st_d = RTS_OFF;
        RTS_OFF:  if (count <= lo) st_d = RTS_ON;
        default:  st_d = RTS_IDLE;
      endcase
    end
    if (off_clr) flag_d = 1'b0;
    if (st_q == RTS_ON && st_d == RTS_OFF && rts_ie) flag_d = 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q   <= RTS_IDLE;
      flag_q <= 1'b0;
    end else begin
      st_q   <= st_d;
      flag_q <= flag_d;
    end
  end

  assign rts_n    = (!auto_en || !rts_req || st_q == RTS_IDLE) ? !rts_req
                                                                : (st_q == RTS_OFF);
  assign off_flag = flag_q;
endmodule

// File: rtl/rx_flow_fifo.sv
module rx_flow_fifo #(
  parameter int DATA_W = 8,
  parameter int ERR_W  = 3,
  parameter int DEPTH  = 128,
  parameter int LVL_W  = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  logic [DATA_W-1:0] wr_data,
  input  logic [ERR_W-1:0]  wr_err,
  input  logic              rd_en,
  input  logic              auto_en,
  input  logic              rts_req,
  input  logic              rts_ie,
  input  logic              rts_off_clr,
  input  logic [LVL_W-1:0]  trig_lvl,
  input  logic [LVL_W-1:0]  hyst,
  output logic              rts_n,
  output logic              rx_trig_irq,
  output logic              rts_off_irq,
  output logic              overrun,
  output logic [DATA_W-1:0] rd_data,
  output logic [ERR_W-1:0]  rd_err
);
  localparam int ENT_W = DATA_W + ERR_W;
  localparam logic [LVL_W-1:0] FULL_LVL = LVL_W'(DEPTH);

  logic [1:0]       rs_q;
  logic             rst_core_n;
  logic [LVL_W-1:0] fill_cnt, lim_hi, lim_lo;
  logic [ENT_W-1:0] head;
  logic             full, empty, push, pop;
  logic             ovr_q, ovr_d;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rs_q <= 2'b00;
    else        rs_q <= {rs_q[0], 1'b1};
  end
  assign rst_core_n = rs_q[1];

  assign full  = (fill_cnt == FULL_LVL);
  assign empty = (fill_cnt == '0);
  assign push  = wr_en && !full;
  assign pop   = rd_en && !empty;

  rxf_store #(.W(ENT_W), .DEPTH(DEPTH), .CNT_W(LVL_W)) u_store (
    .clk   (clk),
    .rst_n (rst_core_n),
    .push  (push),
    .pop   (pop),
    .din   ({wr_err, wr_data}),
    .dout  (head),
    .count (fill_cnt)
  );

  rxf_limits #(.DEPTH(DEPTH), .CNT_W(LVL_W)) u_lim (
    .trig (trig_lvl),
    .hyst (hyst),
    .hi   (lim_hi),
    .lo   (lim_lo)
  );

  rxf_rts_ctl #(.CNT_W(LVL_W)) u_rts (
    .clk      (clk),
    .rst_n    (rst_core_n),
    .auto_en  (auto_en),
    .rts_req  (rts_req),
    .rts_ie   (rts_ie),
    .off_clr  (rts_off_clr),
    .count    (fill_cnt),
    .hi       (lim_hi),
    .lo       (lim_lo),
    .rts_n    (rts_n),
    .off_flag (rts_off_irq)
  );

  always_comb begin
    ovr_d = ovr_q;
    if (wr_en && full) ovr_d = 1'b1;
  end

  always_ff @(posedge clk or negedge rst_core_n) begin
    if (!rst_core_n) ovr_q <= 1'b0;
    else             ovr_q <= ovr_d;
  end

  assign overrun     = ovr_q;
  assign rx_trig_irq = !empty && (fill_cnt >= trig_lvl);
  assign rd_data     = head[DATA_W-1:0];
  assign rd_err      = head[ENT_W-1:DATA_W];
endmodule

// File: rtl/rxf_checks.sv
module rxf_checks #(
  parameter int DEPTH = 128,
  parameter int LVL_W = 8
) (
  input logic             clk,
  input logic             rst_n,
  input logic             wr_en,
  input logic             rd_en,
  input logic [LVL_W-1:0] count,
  input logic [LVL_W-1:0] hi,
  input logic             auto_en,
  input logic             rts_req,
  input logic             rts_n,
  input logic             off_flag,
  input logic             rx_irq,
  input logic             ovr
);
  localparam logic [LVL_W-1:0] FULL_LVL = LVL_W'(DEPTH);

  p_count_bound_r2: assert property (@(posedge clk) disable iff (!rst_n)
    count <= FULL_LVL);

  p_full_drop_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (count == FULL_LVL && wr_en && !rd_en) |=> (count == FULL_LVL));

  p_overrun_sticky_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (count == FULL_LVL && wr_en) |=> ovr);

  p_rw_hold_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (count != '0 && count != FULL_LVL && wr_en && rd_en) |=> $stable(count));

  p_irq_nonempty_r4: assert property (@(posedge clk) disable iff (!rst_n)
    rx_irq |-> (count != '0));

  p_rise_at_upper_r6: assert property (@(posedge clk) disable iff (!rst_n)
    ($rose(rts_n) && auto_en && $past(auto_en) && rts_req && $past(rts_req))
      |-> ($past(count) >= $past(hi)));

  p_flag_with_rts_high_r9: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(off_flag) |-> rts_n);

  p_manual_follow_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (!auto_en && $past(!auto_en)) |-> (rts_n == !rts_req));
endmodule

bind rx_flow_fifo rxf_checks #(.DEPTH(DEPTH), .LVL_W(LVL_W)) u_chk (
  .clk      (clk),
  .rst_n    (rst_core_n),
  .wr_en    (wr_en),
  .rd_en    (rd_en),
  .count    (fill_cnt),
  .hi       (lim_hi),
  .auto_en  (auto_en),
  .rts_req  (rts_req),
  .rts_n    (rts_n),
  .off_flag (rts_off_irq),
  .rx_irq   (rx_trig_irq),
  .ovr      (overrun)
);

// File: tb/rx_flow_fifo_test.sv
`timescale 1ns/1ps
module rx_flow_fifo_test;
  localparam int DEPTH = 128;

  logic       clk = 1'b0;
  logic       rst_n, wr_en, rd_en, auto_en, rts_req, rts_ie, rts_off_clr;
  logic [7:0] wr_data, trig_lvl, hyst, rd_data;
  logic [2:0] wr_err, rd_err;
  logic       rts_n, rx_trig_irq, rts_off_irq, overrun;

  int checks = 0;
  int fails  = 0;
  int wseq   = 0;
  bit done   = 1'b0;
  logic [10:0] exp_q[$];

  always #2 clk = ~clk;

  rx_flow_fifo uut (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_data(wr_data), .wr_err(wr_err),
    .rd_en(rd_en), .auto_en(auto_en), .rts_req(rts_req), .rts_ie(rts_ie),
    .rts_off_clr(rts_off_clr), .trig_lvl(trig_lvl), .hyst(hyst), .rts_n(rts_n),
    .rx_trig_irq(rx_trig_irq), .rts_off_irq(rts_off_irq), .overrun(overrun),
    .rd_data(rd_data), .rd_err(rd_err)
  );

  task automatic chk(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  // Scoreboard monitor: compares the head on each accepted read, records writes.
  always begin
    @(negedge clk);
    #1;
    if (rst_n && !done) begin
      int sz;
      sz = exp_q.size();
      if (rd_en && sz > 0) begin
        chk("R1 head order/tags", int'({rd_err, rd_data}), int'(exp_q[0]));
        void'(exp_q.pop_front());
      end
      if (wr_en && sz < DEPTH) exp_q.push_back({wr_err, wr_data});
    end
  end

  task automatic cyc(input bit w, input bit r);
    @(negedge clk);
    wr_en   = w;
    rd_en   = r;
    wr_data = 8'(wseq * 37 + 5);
    wr_err  = 3'(wseq ^ (wseq >> 3));
    if (w) wseq++;
    @(posedge clk);
    #1;
    wr_en = 1'b0;
    rd_en = 1'b0;
  endtask

  task automatic fill_to(input int n);
    while (exp_q.size() < n) cyc(1'b1, 1'b0);
  endtask

  task automatic drain_to(input int n);
    while (exp_q.size() > n) cyc(1'b0, 1'b1);
  endtask

  initial begin
    #(200000 * 4);
    if (!done) begin
      done = 1'b1;
      fails++;
      $display("FAIL watchdog actual=timeout expected=finish");
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  end

  initial begin
    rst_n = 1'b0; wr_en = 1'b0; rd_en = 1'b0; wr_data = '0; wr_err = '0;
    auto_en = 1'b1; rts_req = 1'b0; rts_ie = 1'b1; rts_off_clr = 1'b0;
    trig_lvl = 8'd16; hyst = 8'd8;
    repeat (3) @(posedge clk);
    #1 rst_n = 1'b1;
    repeat (4) cyc(1'b0, 1'b0);

    chk("R11 rts_n", rts_n, 1);
    chk("R11 rx_trig_irq", rx_trig_irq, 0);
    chk("R11 rts_off_irq", rts_off_irq, 0);
    chk("R11 overrun", overrun, 0);

    // R5: no request -> pin stays high even past the upper limit
    fill_to(30);
    cyc(1'b0, 1'b0); cyc(1'b0, 1'b0);
    chk("R5 no request rts_n", rts_n, 1);
    chk("R9 no flag without auto", rts_off_irq, 0);
    drain_to(0);
    // R3: read while empty is ignored
    cyc(1'b0, 1'b1);
    cyc(1'b1, 1'b0);
    chk("R3 one entry after empty read", rx_trig_irq, 0);
    cyc(1'b0, 1'b1);

    // R5: start automatic control
    rts_req = 1'b1;
    cyc(1'b0, 1'b0);
    chk("R5 started rts_n", rts_n, 0);
    fill_to(15);
    chk("R4 below trigger", rx_trig_irq, 0);
    fill_to(16);
    chk("R4 at trigger", rx_trig_irq, 1);
    chk("R6 low at trigger", rts_n, 0);
    fill_to(23);
    cyc(1'b0, 1'b0);
    chk("R6 low below upper", rts_n, 0);
    fill_to(24);
    cyc(1'b0, 1'b0);
    chk("R6 high at upper", rts_n, 1);
    chk("R9 flag set", rts_off_irq, 1);
    fill_to(DEPTH);
    chk("R8 accepted to full", exp_q.size(), DEPTH);
    chk("R2 no overrun yet", overrun, 0);
    cyc(1'b1, 1'b0);
    chk("R2 overrun set", overrun, 1);
    cyc(1'b0, 1'b1);
    cyc(1'b1, 1'b1);
    cyc(1'b1, 1'b1);
    chk("R3 rw keeps level", exp_q.size(), DEPTH - 1);
    drain_to(9);
    cyc(1'b0, 1'b0);
    chk("R7 high above lower", rts_n, 1);
    drain_to(8);
    cyc(1'b0, 1'b0);
    chk("R7 low at lower", rts_n, 0);
    chk("R2 overrun sticky", overrun, 1);
    drain_to(0);
    chk("R4 empty no irq", rx_trig_irq, 0);

    @(negedge clk) rts_off_clr = 1'b1;
    @(posedge clk) #1 rts_off_clr = 1'b0;
    chk("R9 flag cleared", rts_off_irq, 0);

    // R9: interrupt enable off
    rts_ie = 1'b0;
    fill_to(24);
    cyc(1'b0, 1'b0);
    chk("R9 rts_n high ie off", rts_n, 1);
    chk("R9 no flag ie off", rts_off_irq, 0);
    drain_to(0);
    cyc(1'b0, 1'b0);
    rts_ie = 1'b1;

    // R12: saturated upper limit, lower limit 100
    trig_lvl = 8'd120; hyst = 8'd20;
    cyc(1'b0, 1'b0);
    fill_to(127);
    cyc(1'b0, 1'b0);
    chk("R12 low at 127", rts_n, 0);
    fill_to(128);
    cyc(1'b0, 1'b0);
    chk("R12 high at 128", rts_n, 1);
    drain_to(101);
    cyc(1'b0, 1'b0);
    chk("R7 high at 101", rts_n, 1);
    drain_to(100);
    cyc(1'b0, 1'b0);
    chk("R7 low at 100", rts_n, 0);
    drain_to(0);

    // R12: floored lower limit
    trig_lvl = 8'd4; hyst = 8'd10;
    cyc(1'b0, 1'b0);
    fill_to(14);
    cyc(1'b0, 1'b0);
    chk("R12 high at 14", rts_n, 1);
    drain_to(1);
    cyc(1'b0, 1'b0);
    chk("R12 high at 1", rts_n, 1);
    drain_to(0);
    cyc(1'b0, 1'b0);
    chk("R12 low at 0", rts_n, 0);

    // R10: manual mode
    auto_en = 1'b0;
    cyc(1'b0, 1'b0);
    chk("R10 follows req=1", rts_n, 0);
    rts_req = 1'b0;
    cyc(1'b0, 1'b0);
    chk("R10 follows req=0", rts_n, 1);

    done = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule